// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Software programs a format byte that sets the character length, the stop bits, the parity and a forced break. It also programs a 16-bit rate divisor. It then writes characters into a one-byte holding register. A tick generator divides the core clock by the divisor to get a sixteen-times oversampling tick. The shifter holds every serial bit for sixteen of those ticks.

The register port is a plain write strobe with an address and a data byte. It has no ready signal. Every write is taken in the cycle it is presented, so the port never stalls the writer. Flow control is left to software, which polls the holding-empty flag before it writes. A character written while the holding register is still full replaces the waiting character. The two divisor bytes share offsets with the data register and the unused enable register. The divisor-access bit of the format byte selects which of the two sets those offsets reach.

Top module: `sertx_top`

## Requirements
- R1: Format bits 1..0 give the character length: 00 is five data bits, 01 six, 10 seven, 11 eight. Only that many low-order bits of the character are sent.
- R2: Format bit 2 sets the stop bits: 0 is one stop bit, 1 is two. A character already waiting starts its start bit right after the last stop bit.
- R3: Format bits 5..3 set the parity bit that follows the data: 000 sends no parity, 001 makes the count of ones odd, 011 makes it even, 101 always sends 1, 111 always sends 0.
- R4: While format bit 6 is 1, the line is driven low from the second clock after the write. The line returns to its normal value once the bit is cleared. The break changes neither status flag.
- R5: While format bit 7 is 1, writes to offset 0 and offset 1 load the low and high divisor bytes and never fill the holding register. While bit 7 is 0, offset 0 is the data register, a write to offset 1 has no effect, and offset 3 always holds the format byte.
- R6: A write to offset 0 with bit 7 clear fills the holding register, and the status byte shows it full from the next cycle. At the next tick the character moves into the shifter and the holding register reads empty again. A second write before that move replaces the waiting character.
- R7: Status bit 5 is 1 when the holding register is empty. Status bit 6 is 1 when both the holding register and the shifter are empty. All other status bits are 0.
- R8: The idle line is high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits.
- R9: Every serial bit lasts 16 × divisor clock cycles.
- R10: A divisor of zero behaves as one, so each bit lasts 16 clock cycles.
- R11: The format is captured when a character enters the shifter. A format write during a frame changes only later frames, apart from the break bit.
- R12: After reset the line is high, the status byte reads 0x60, the format is eight data bits with one stop bit and no parity, and the divisor is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset: 0 data / divisor low, 1 divisor high, 3 format |
| wr_data | input | 8 | Write data byte |
| txd | output | 1 | Serial output line, high when idle |
| line_status | output | 8 | Status byte: bit 5 holding empty, bit 6 transmitter empty |

## Verification
The status byte changes one cycle after a data write: it reads full on the first falling clock edge after the write. With a divisor of one, it reads holding-empty again on the next falling edge, because the move into the shifter waits only for the next tick. The serial line is registered. A break therefore shows on the second falling edge after the format write. A start bit appears one cycle after the tick that loads the shifter. The bench waits for that start edge. It then samples each bit at the falling edge nearest the middle of the bit, that is half a bit period and then whole bit periods after the start, and it measures bit widths by counting low cycles. As a result the checks do not depend on the free-running phase of the tick counter.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int BYTE_W      = 8;
  localparam int ADDR_DATA   = 0;
  localparam int ADDR_FMT    = 3;
  localparam int FMT_BREAK   = 6;
  localparam int FMT_DIVSEL  = 7;
  localparam int STAT_HOLD_E = 5;
  localparam int STAT_ALL_E  = 6;
  localparam logic [7:0] FMT_RESET = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       two_stop;
    logic       par_en;
    logic       even_sel;
    logic       stick;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_fmt(input logic [7:0] fmt);
    frame_cfg_t c;
    c.nbits    = 4'd5 + {2'b00, fmt[1:0]};
    c.two_stop = fmt[2];
    c.par_en   = fmt[3];
    c.even_sel = fmt[4];
    c.stick    = fmt[5];
    return c;
  endfunction

  function automatic logic parity_bit(input logic [BYTE_W-1:0] d, input frame_cfg_t c);
    logic x;
    x = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (4'(i) < c.nbits) x = x ^ d[i];
    end
    if (c.stick) return ~c.even_sel;
    return c.even_sel ? x : ~x;
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_div;

  // a zero divisor is clamped to one so the tick never stops
  assign eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick    = (cnt_q >= (eff_div - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        fmt,
  output logic [DIV_W-1:0]  divisor,
  output logic              wr_hold,
  output logic [7:0]        hold_byte
);

  localparam int NBYTES = DIV_W / 8;

  logic [7:0] fmt_q;
  logic       divsel;

  assign divsel    = fmt_q[FMT_DIVSEL];
  assign fmt       = fmt_q;
  assign wr_hold   = wr_en && !divsel && (wr_addr == ADDR_W'(ADDR_DATA));
  assign hold_byte = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_RESET;
    end else if (wr_en && (wr_addr == ADDR_W'(ADDR_FMT))) begin
      fmt_q <= wr_data;
    end
  end

  // one divisor byte per aliased offset, reachable only with divsel set
  for (genvar i = 0; i < NBYTES; i++) begin : g_div
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= (i == 0) ? 8'd1 : 8'd0;
      end else if (wr_en && divsel && (wr_addr == ADDR_W'(i))) begin
        byte_q <= wr_data;
      end
    end
    assign divisor[8*i +: 8] = byte_q;
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_hold,
  input  logic [7:0] hold_byte,
  input  logic [7:0] fmt,
  output logic       txd,
  output logic       hold_empty,
  output logic       all_empty
);

  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  tx_state_e  state_q;
  logic [SUB_W-1:0] sub_q;
  logic [3:0] bitcnt_q;
  logic [7:0] hold_q;
  logic       hold_full_q;
  logic [7:0] shreg_q;
  frame_cfg_t cfg_q;
  frame_cfg_t cfg_in;
  logic       pbit_q;
  logic       stop2_q;
  logic       txd_q;
  logic       bit_end;
  logic       frame_done;
  logic       load;
  logic       line;

  assign cfg_in     = decode_fmt(fmt);
  assign bit_end    = tick && (sub_q == SUB_LAST);
  assign frame_done = (state_q == ST_STOP) && bit_end && (!cfg_q.two_stop || stop2_q);
  assign load       = tick && hold_full_q && ((state_q == ST_IDLE) || frame_done);

  // holding register: a write wins over a same-cycle move into the shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else begin
      if (load) hold_full_q <= 1'b0;
      if (wr_hold) begin
        hold_q      <= hold_byte;
        hold_full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (load || (state_q == ST_IDLE)) begin
      sub_q <= '0;
    end else if (tick) begin
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      cfg_q    <= decode_fmt(FMT_RESET);
      pbit_q   <= 1'b0;
      stop2_q  <= 1'b0;
    end else if (load) begin
      state_q  <= ST_START;
      bitcnt_q <= '0;
      shreg_q  <= hold_q;
      cfg_q    <= cfg_in;
      pbit_q   <= parity_bit(hold_q, cfg_in);
      stop2_q  <= 1'b0;
    end else if (frame_done) begin
      state_q <= ST_IDLE;
    end else if (bit_end) begin
      unique case (state_q)
        ST_START: begin
          state_q  <= ST_DATA;
          bitcnt_q <= '0;
        end
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (bitcnt_q == (cfg_q.nbits - 4'd1)) begin
            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end
        end
        ST_PAR:  state_q <= ST_STOP;
        ST_STOP: stop2_q <= 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = pbit_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1;
    end else begin
      txd_q <= fmt[FMT_BREAK] ? 1'b0 : line;
    end
  end

  assign txd        = txd_q;
  assign hold_empty = !hold_full_q;
  assign all_empty  = !hold_full_q && (state_q == ST_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              txd,
  output logic [7:0]        line_status
);

  logic [7:0]       fmt_w;
  logic [DIV_W-1:0] div_w;
  logic             tick_w;
  logic             wr_hold_w;
  logic [7:0]       hold_byte_w;
  logic             hold_empty_w;
  logic             all_empty_w;

  sertx_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .fmt       (fmt_w),
    .divisor   (div_w),
    .wr_hold   (wr_hold_w),
    .hold_byte (hold_byte_w)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (div_w),
    .tick    (tick_w)
  );

  sertx_shifter #(.OVS(OVS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .wr_hold    (wr_hold_w),
    .hold_byte  (hold_byte_w),
    .fmt        (fmt_w),
    .txd        (txd),
    .hold_empty (hold_empty_w),
    .all_empty  (all_empty_w)
  );

  always_comb begin
    line_status              = '0;
    line_status[STAT_HOLD_E] = hold_empty_w;
    line_status[STAT_ALL_E]  = all_empty_w;
  end

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              txd,
  input logic [7:0]        line_status,
  input logic [7:0]        fmt,
  input logic [DIV_W-1:0]  divisor,
  input logic              tick
);

  AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    fmt[6] |=> !txd); // R4

  AST_EMPTY_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[6] |-> line_status[5]); // R7

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(0)) && !fmt[7]) |=> !line_status[5]); // R6

  AST_DIVSEL_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt[7] && line_status[5]) |=> line_status[5]); // R5

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_status[6] && !fmt[6]) |=> txd); // R8

  AST_ZERO_DIV_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> tick); // R10

endmodule

bind sertx_top sertx_checker #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .txd         (txd),
  .line_status (line_status),
  .fmt         (fmt_w),
  .divisor     (div_w),
  .tick        (tick_w)
);

// File: tb/sertx_top_bench.sv
module sertx_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       txd;
  logic [7:0] line_status;

  int checks = 0;
  int errors = 0;
  int cur_div = 1;
  bit done = 1'b0;

  sertx_top u_sertx_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .txd         (txd),
    .line_status (line_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] fmt_of(input int len, input int pm, input bit two, input bit brk);
    logic [2:0] pc;
    case (pm)
      1: pc = 3'b001;
      2: pc = 3'b011;
      3: pc = 3'b101;
      4: pc = 3'b111;
      default: pc = 3'b000;
    endcase
    return {1'b0, brk, pc, two, 2'(len - 5)};
  endfunction

  function automatic int frame_len(input int len, input int pm, input bit two);
    return 1 + len + ((pm != 0) ? 1 : 0) + (two ? 2 : 1);
  endfunction

  // pm: 0 none, 1 odd, 2 even, 3 always one, 4 always zero
  function automatic logic [15:0] frame_of(input logic [7:0] d, input int len, input int pm, input bit two);
    logic [15:0] f;
    int n;
    logic x;
    f = '0; n = 1; x = 1'b0;
    for (int i = 0; i < len; i++) begin
      f[n] = d[i]; x = x ^ d[i]; n++;
    end
    if (pm != 0) begin
      case (pm)
        1: f[n] = ~x;
        2: f[n] = x;
        3: f[n] = 1'b1;
        default: f[n] = 1'b0;
      endcase
      n++;
    end
    f[n] = 1'b1; n++;
    if (two) f[n] = 1'b1;
    return f;
  endfunction

  task automatic wait_low(input string req);
    int t = 0;
    while (txd !== 1'b0 && t < LIMIT) begin
      @(negedge clk); t++;
    end
    if (t >= LIMIT) chk({req, " start bit timeout"}, 1, 0);
  endtask

  task automatic capture(input string req, input int nb, output logic [15:0] bits);
    int p;
    p = 16 * ((cur_div == 0) ? 1 : cur_div);
    bits = '0;
    wait_low(req);
    repeat (p/2) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < nb; k++) begin
      repeat (p) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  task automatic low_width(input string req, output int w);
    w = 0;
    wait_low(req);
    while (txd === 1'b0 && w < LIMIT) begin
      w++; @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (line_status[6] !== 1'b1 && t < LIMIT) begin
      @(negedge clk); t++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_hold_empty();
    int t = 0;
    while (line_status[5] !== 1'b1 && t < LIMIT) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic set_div(input int d);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'(d));
    wr(3'd1, 8'(d >> 8));
    wr(3'd3, 8'h03);
    cur_div = d;
  endtask

  task automatic send_check(input string req, input logic [7:0] d, input int len, input int pm, input bit two);
    logic [15:0] got, exp;
    int n;
    n = frame_len(len, pm, two);
    exp = frame_of(d, len, pm, two);
    wait_idle();
    wr(3'd3, fmt_of(len, pm, two, 1'b0));
    wr(3'd0, d);
    capture(req, n, got);
    chk(req, 32'(got & ((16'h1 << n) - 16'h1)), 32'(exp));
    wait_idle();
    chk({req, " idle line high"}, 32'(txd), 1);
  endtask

  task automatic t_reset();
    chk("R12 reset line", 32'(txd), 1);
    chk("R12 reset status", 32'(line_status), 32'h60);
    send_check("R12 reset format 8N1", 8'hC3, 8, 0, 1'b0);
  endtask

  task automatic t_length();
    send_check("R1 five bits", 8'hB5, 5, 0, 1'b0);
    send_check("R1 six bits", 8'hEA, 6, 0, 1'b0);
    send_check("R1 seven bits", 8'hD9, 7, 0, 1'b0);
    send_check("R1 eight bits", 8'h96, 8, 0, 1'b0);
  endtask

  task automatic t_frame();
    send_check("R8 frame 5A", 8'h5A, 8, 0, 1'b0);
    send_check("R8 frame 81", 8'h81, 8, 0, 1'b0);
  endtask

  task automatic t_parity();
    send_check("R3 odd", 8'h35, 7, 1, 1'b0);
    send_check("R3 even", 8'h35, 7, 2, 1'b0);
    send_check("R3 mark", 8'h35, 7, 3, 1'b0);
    send_check("R3 space", 8'hCA, 7, 4, 1'b0);
    send_check("R3 even 8 bit", 8'h7F, 8, 2, 1'b0);
  endtask

  task automatic t_stop();
    logic [15:0] got, exp;
    wait_idle();
    wr(3'd3, fmt_of(8, 0, 1'b1, 1'b0));
    wr(3'd0, 8'hA5);
    wait_hold_empty();
    wr(3'd0, 8'h00);
    capture("R2", 12, got);
    exp = frame_of(8'hA5, 8, 0, 1'b1);
    exp[11] = 1'b0;
    chk("R2 two stop bits then next start", 32'(got & 16'h0FFF), 32'(exp & 16'h0FFF));
    wait_idle();
  endtask

  task automatic t_hold();
    logic [15:0] got;
    wait_idle();
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h11);
    chk("R6 status full after write", 32'(line_status), 32'h00);
    @(negedge clk);
    chk("R6 holding empty after move", 32'(line_status), 32'h20);
    wait_idle();
    wr(3'd0, 8'h0F);
    wait_hold_empty();
    wr(3'd0, 8'h3C);
    wr(3'd0, 8'hE7);
    capture("R6 first", 10, got);
    chk("R6 first frame", 32'(got & 16'h03FF), 32'(frame_of(8'h0F, 8, 0, 1'b0)));
    capture("R6 replaced", 10, got);
    chk("R6 replaced byte sent", 32'(got & 16'h03FF), 32'(frame_of(8'hE7, 8, 0, 1'b0)));
    wait_idle();
    chk("R7 status after drain", 32'(line_status), 32'h60);
  endtask

  task automatic t_latch();
    logic [15:0] got;
    wait_idle();
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h55);
    wait_hold_empty();
    wr(3'd3, 8'h00);
    capture("R11", 10, got);
    chk("R11 running frame keeps 8N1", 32'(got & 16'h03FF), 32'(frame_of(8'h55, 8, 0, 1'b0)));
    wait_idle();
    send_check("R11 next frame uses new format", 8'h3F, 5, 0, 1'b0);
  endtask

  task automatic t_break();
    wait_idle();
    wr(3'd3, 8'h43);
    @(negedge clk);
    chk("R4 break drives low", 32'(txd), 0);
    repeat (100) @(negedge clk);
    chk("R4 break held", 32'(txd), 0);
    chk("R4 status unchanged", 32'(line_status), 32'h60);
    wr(3'd3, 8'h03);
    @(negedge clk);
    chk("R4 line released", 32'(txd), 1);
  endtask

  task automatic t_divsel();
    int w;
    wait_idle();
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00);
    chk("R5 divisor writes leave holding empty", 32'(line_status), 32'h60);
    wr(3'd3, 8'h03);
    cur_div = 2;
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h01);
    low_width("R5", w);
    chk("R5 divisor via aliased offsets", 32'(w), 32);
    wait_idle();
  endtask

  task automatic t_rate();
    int w;
    set_div(3);
    wait_idle();
    wr(3'd0, 8'h01);
    low_width("R9", w);
    chk("R9 bit width divisor 3", 32'(w), 48);
    wait_idle();
    send_check("R9 frame at divisor 3", 8'h6B, 8, 0, 1'b0);
    set_div(0);
    wait_idle();
    wr(3'd0, 8'h01);
    low_width("R10", w);
    chk("R10 zero divisor acts as one", 32'(w), 16);
    wait_idle();
    set_div(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_length();
    t_frame();
    t_parity();
    t_stop();
    t_hold();
    t_latch();
    t_break();
    t_divsel();
    t_rate();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule